// File: doc/BRIEF.md
# Shared-Adder Oscillator Phase Bank

This block keeps the phase of 96 oscillators (16 voices, each with 6 operators) using one 24-bit adder and one 96-entry phase memory, so no oscillator needs its own register. Each audio sample starts with a one-cycle `sync_i` pulse. The block then visits every oscillator slot once in a fixed order. In each slot it adds that slot's frequency increment to the stored phase and writes the sum back. It also returns the new phase plus a per-slot modulation offset on the output.

The block tells the surrounding engine which slot it is working on through `slot_op_o` and `slot_voice_o`. In that same cycle the engine must supply `freq_i`, `offs_i` and `ksync_i` for that slot. The slots run operator-major, so the same voice on the next operator comes exactly 16 slots later. A modulator's output can therefore be fed into the next operator's offset through a fixed 16-deep delay. A key-sync request clears one slot's phase and leaves every other slot untouched.

The control is a four-state machine:
- INIT sweeps zeros into all 96 entries after reset, then goes to IDLE.
- IDLE waits for `sync_i` and then goes to ARM.
- ARM waits one cycle, loads the slot counters and goes to RUN.
- RUN processes one slot per clock. After the last slot it goes back to IDLE.

Top module: `phase_accum_bank`

## Requirements
- R1: While `rst` is high and for the 96 cycles after it falls, the block is in its clearing sweep: `ready_o` is 0, `sync_i` is ignored and `slot_req_o` stays 0. `ready_o` is 1 in the 96th cycle after reset, counted at falling clock edges. After the sweep, every stored phase reads as zero.
- R2: A `sync_i` pulse sampled with `ready_o` high gives one cycle with `slot_req_o` low (ARM), followed by the first slot, so slot processing starts two clock cycles after the pulse.
- R3: A pass covers 96 consecutive `slot_req_o` cycles in operator-major order. `slot_op_o` holds the operator index (operator number minus 1) and counts down from 5 to 0. Within each operator, `slot_voice_o` (channel number minus 1) counts up from 0 to 15.
- R4: On `phase_vld_o`, a voice's result for operator index k-1 appears exactly 16 cycles after its result for operator index k.
- R5: For a slot without key sync, the stored phase becomes (stored + `freq_i`) mod 2^24.
- R6: One cycle after a slot, `phase_vld_o` is 1 and `phase_o` = (updated phase + `offs_i`) mod 2^24, tagged with that slot's `phase_op_o` and `phase_voice_o`. The offset is never written back to the stored phase.
- R7: If `ksync_i` is 1 during a slot, that slot's stored phase becomes 0 whatever `freq_i` is, its output equals `offs_i`, and no other slot's phase changes.
- R8: `done_o` is a one-cycle pulse that comes together with the output of the last slot (operator index 0, voice 15). After it the block stays idle until the next `sync_i`.
- R9: A `sync_i` pulse that arrives during ARM or RUN is ignored: the running pass continues unchanged and no new pass starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Sample-start pulse |
| freq_i | input | 24 | Phase increment for the current slot |
| offs_i | input | 24 | Modulation offset for the current slot |
| ksync_i | input | 1 | Clear the current slot's phase |
| ready_o | output | 1 | Idle and able to accept `sync_i` |
| slot_req_o | output | 1 | A slot is being processed in this cycle |
| slot_op_o | output | 3 | Operator index of the current slot |
| slot_voice_o | output | 4 | Voice index of the current slot |
| phase_vld_o | output | 1 | `phase_o` is valid |
| phase_o | output | 24 | Updated phase plus offset |
| phase_op_o | output | 3 | Operator index of `phase_o` |
| phase_voice_o | output | 4 | Voice index of `phase_o` |
| done_o | output | 1 | Last output of the pass |

## Verification
The bench goes after three groups of corner cases.

Phase arithmetic:
- Increments that push the phase past 2^24. A design that saturated instead of wrapping, or that kept a carry, would give wrong results from then on.
- Offsets applied in one pass and removed in the next. If the offset leaked into the stored phase, the second pass would be off by the earlier offset.
- Key-sync on a single slot while that slot also gets a nonzero increment. If key sync lost the priority, or cleared a neighbouring slot, the reference model would disagree on that slot or on the next one.

Sequencing:
- A pass with the wrong start delay, a wrong operator direction, or a wrong voice direction shows up as a slot index mismatch in the very first cycles.
- A stray `sync_i` during a pass or during the clearing sweep would restart the pass, or start one too early.

Reset:
- A second reset in the middle of operation must leave all phases reading zero. A design that skipped the sweep would return stale phases there.

// File: rtl/pab_pkg.sv
package pab_pkg;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_ARM,
        ST_RUN
    } pab_state_e;

endpackage

// File: rtl/pab_seq.sv
module pab_seq
    import pab_pkg::*;
#(
    parameter int VOICES = 16,
    parameter int OPS    = 6,
    parameter int SW     = 7,
    parameter int OPW    = 3,
    parameter int VW     = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sync_i,
    output logic           ready_o,
    output logic           run_o,
    output logic           init_o,
    output logic           last_o,
    output logic [OPW-1:0] op_o,
    output logic [VW-1:0]  voice_o,
    output logic           mem_we_o,
    output logic [SW-1:0]  mem_addr_o
);
    localparam int SLOTS = VOICES * OPS;

    pab_state_e     state_q, state_d;
    logic [SW-1:0]  sweep_q;
    logic [OPW-1:0] op_q;
    logic [VW-1:0]  voice_q;
    logic           last_slot;
    logic           sweep_end;

    assign last_slot = (op_q == '0) && (voice_q == VW'(VOICES - 1));
    assign sweep_end = (sweep_q == SW'(SLOTS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_INIT;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (sweep_end) state_d = ST_IDLE;
            ST_IDLE: if (sync_i)    state_d = ST_ARM;
            ST_ARM:                 state_d = ST_RUN;
            ST_RUN:  if (last_slot) state_d = ST_IDLE;
            default:                state_d = ST_INIT;
        endcase
    end

    // Counters
    always_ff @(posedge clk) begin
        if (rst) begin
            sweep_q <= '0;
            op_q    <= '0;
            voice_q <= '0;
        end else begin
            unique case (state_q)
                ST_INIT: sweep_q <= sweep_q + SW'(1);
                ST_ARM: begin
                    op_q    <= OPW'(OPS - 1);
                    voice_q <= '0;
                end
                ST_RUN: begin
                    if (voice_q == VW'(VOICES - 1)) begin
                        voice_q <= '0;
                        op_q    <= op_q - OPW'(1);
                    end else begin
                        voice_q <= voice_q + VW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ready_o    = 1'b0;
        run_o      = 1'b0;
        init_o     = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = SW'(op_q) * SW'(VOICES) + SW'(voice_q);
        unique case (state_q)
            ST_INIT: begin
                init_o     = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = sweep_q;
            end
            ST_IDLE: ready_o = 1'b1;
            ST_RUN: begin
                run_o    = 1'b1;
                mem_we_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign last_o  = run_o && last_slot;
    assign op_o    = op_q;
    assign voice_o = voice_q;

endmodule

// File: rtl/pab_mem.sv
module pab_mem #(
    parameter int DEPTH = 96,
    parameter int AW    = 7,
    parameter int DW    = 24
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = store[addr];

endmodule

// File: rtl/pab_dp.sv
module pab_dp #(
    parameter int PW  = 24,
    parameter int OPW = 3,
    parameter int VW  = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           init_i,
    input  logic           run_i,
    input  logic           last_i,
    input  logic           ksync_i,
    input  logic [PW-1:0]  freq_i,
    input  logic [PW-1:0]  offs_i,
    input  logic [PW-1:0]  rdata_i,
    input  logic [OPW-1:0] op_i,
    input  logic [VW-1:0]  voice_i,
    output logic [PW-1:0]  wdata_o,
    output logic           vld_o,
    output logic [PW-1:0]  phase_o,
    output logic [OPW-1:0] op_o,
    output logic [VW-1:0]  voice_o,
    output logic           done_o
);
    logic [PW-1:0] accum;

    assign accum   = (ksync_i) ? '0 : rdata_i + freq_i;
    assign wdata_o = (init_i) ? '0 : accum;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            vld_o  <= run_i;
            done_o <= last_i;
        end
    end

    always_ff @(posedge clk) begin
        if (run_i) begin
            phase_o <= accum + offs_i;
            op_o    <= op_i;
            voice_o <= voice_i;
        end
    end

endmodule

// File: rtl/phase_accum_bank.sv
module phase_accum_bank #(
    parameter int VOICES = 16,
    parameter int OPS    = 6,
    parameter int PW     = 24,
    localparam int SLOTS = VOICES * OPS,
    localparam int SW    = $clog2(SLOTS),
    localparam int OPW   = $clog2(OPS),
    localparam int VW    = $clog2(VOICES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sync_i,
    input  logic [PW-1:0]  freq_i,
    input  logic [PW-1:0]  offs_i,
    input  logic           ksync_i,
    output logic           ready_o,
    output logic           slot_req_o,
    output logic [OPW-1:0] slot_op_o,
    output logic [VW-1:0]  slot_voice_o,
    output logic           phase_vld_o,
    output logic [PW-1:0]  phase_o,
    output logic [OPW-1:0] phase_op_o,
    output logic [VW-1:0]  phase_voice_o,
    output logic           done_o
);
    logic          init_w;
    logic          last_w;
    logic          we_w;
    logic [SW-1:0] addr_w;
    logic [PW-1:0] rdata_w;
    logic [PW-1:0] wdata_w;

    pab_seq #(
        .VOICES(VOICES), .OPS(OPS), .SW(SW), .OPW(OPW), .VW(VW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_i),
        .ready_o    (ready_o),
        .run_o      (slot_req_o),
        .init_o     (init_w),
        .last_o     (last_w),
        .op_o       (slot_op_o),
        .voice_o    (slot_voice_o),
        .mem_we_o   (we_w),
        .mem_addr_o (addr_w)
    );

    pab_mem #(.DEPTH(SLOTS), .AW(SW), .DW(PW)) u_mem (
        .clk   (clk),
        .we    (we_w),
        .addr  (addr_w),
        .wdata (wdata_w),
        .rdata (rdata_w)
    );

    pab_dp #(.PW(PW), .OPW(OPW), .VW(VW)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .init_i  (init_w),
        .run_i   (slot_req_o),
        .last_i  (last_w),
        .ksync_i (ksync_i),
        .freq_i  (freq_i),
        .offs_i  (offs_i),
        .rdata_i (rdata_w),
        .op_i    (slot_op_o),
        .voice_i (slot_voice_o),
        .wdata_o (wdata_w),
        .vld_o   (phase_vld_o),
        .phase_o (phase_o),
        .op_o    (phase_op_o),
        .voice_o (phase_voice_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/pab_chk.sv
module pab_chk #(
    parameter int VOICES = 16,
    parameter int OPW    = 3,
    parameter int VW     = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           sync_i,
    input logic           ready_o,
    input logic           slot_req_o,
    input logic [OPW-1:0] slot_op_o,
    input logic [VW-1:0]  slot_voice_o,
    input logic           phase_vld_o,
    input logic [OPW-1:0] phase_op_o,
    input logic [VW-1:0]  phase_voice_o,
    input logic           done_o
);
    // R1
    sweep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        slot_req_o |-> !ready_o);

    // R2
    start_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_o && sync_i) |=> (!slot_req_o ##1 slot_req_o));

    // R3
    pass_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_req_o && !(slot_op_o == '0 && slot_voice_o == VW'(VOICES - 1)))
        |=> slot_req_o);

    // R3
    voice_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_req_o && slot_voice_o != VW'(VOICES - 1))
        |=> (slot_voice_o == $past(slot_voice_o) + VW'(1)
             && slot_op_o == $past(slot_op_o)));

    // R6
    out_follows_chk: assert property (@(posedge clk) disable iff (rst)
        slot_req_o |=> phase_vld_o);

    // R6
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_req_o |=> !phase_vld_o);

    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (phase_vld_o && phase_op_o == '0
                    && phase_voice_o == VW'(VOICES - 1)));

    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_req_o && !(slot_op_o == '0 && slot_voice_o == VW'(VOICES - 1)))
        |=> !ready_o);

endmodule

bind phase_accum_bank pab_chk #(.VOICES(VOICES), .OPW(OPW), .VW(VW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sync_i        (sync_i),
    .ready_o       (ready_o),
    .slot_req_o    (slot_req_o),
    .slot_op_o     (slot_op_o),
    .slot_voice_o  (slot_voice_o),
    .phase_vld_o   (phase_vld_o),
    .phase_op_o    (phase_op_o),
    .phase_voice_o (phase_voice_o),
    .done_o        (done_o)
);

// File: tb/tb_phase_accum_bank.sv
`timescale 1ns/1ps
module tb_phase_accum_bank;
    localparam int V = 16;
    localparam int O = 6;
    localparam int N = V * O;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_i = 1'b0;
    logic [23:0] freq_i = '0;
    logic [23:0] offs_i = '0;
    logic        ksync_i = 1'b0;
    logic        ready_o, slot_req_o, phase_vld_o, done_o;
    logic [2:0]  slot_op_o, phase_op_o;
    logic [3:0]  slot_voice_o, phase_voice_o;
    logic [23:0] phase_o;

    int nvec = 0;
    int nerr = 0;
    int cyc  = 0;
    bit finished = 1'b0;

    logic [23:0] ref_ph [N];
    int          tstamp [N];

    phase_accum_bank dut (
        .clk(clk), .rst(rst), .sync_i(sync_i), .freq_i(freq_i),
        .offs_i(offs_i), .ksync_i(ksync_i), .ready_o(ready_o),
        .slot_req_o(slot_req_o), .slot_op_o(slot_op_o),
        .slot_voice_o(slot_voice_o), .phase_vld_o(phase_vld_o),
        .phase_o(phase_o), .phase_op_o(phase_op_o),
        .phase_voice_o(phase_voice_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL watchdog: run hung, act=%0d expected<150000", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] upd(input logic [23:0] ph, input logic [23:0] f, input bit ks);
        return ks ? 24'd0 : ph + f;
    endfunction

    task automatic clear_ref();
        for (int i = 0; i < N; i++) ref_ph[i] = '0;
    endtask

    // R1: reset, then clearing sweep with a stray sync
    task automatic do_reset();
        int k;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_ref();
        chk(ready_o == 1'b0, "R1 ready low at reset", ready_o, 0);
        chk(phase_vld_o == 1'b0 && done_o == 1'b0, "R1 outputs quiet", phase_vld_o, 0);
        k = 0;
        while (!ready_o && k < 200) begin
            @(negedge clk);
            k++;
            sync_i = (k == 10);
            if (slot_req_o) chk(1'b0, "R1 slot during sweep", 1, 0);
        end
        sync_i = 1'b0;
        chk(k == N, "R1 sweep length", k, N);
        repeat (4) begin
            @(negedge clk);
            chk(!slot_req_o && ready_o, "R1 sync in sweep ignored", slot_req_o, 0);
        end
    endtask

    // mode: 0 random, 1 all zero, 2 wrap, 3 single key sync; inj = slot to inject sync (-1 none)
    task automatic pass(input int mode, input int inj);
        logic [23:0] exp_out, prev_exp;
        int prev_op, prev_v, ksel;
        ksel = $urandom_range(N - 1);
        prev_exp = '0; prev_op = 0; prev_v = 0;
        @(negedge clk);
        chk(ready_o == 1'b1, "R8 idle before pass", ready_o, 1);
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        chk(slot_req_o == 1'b0, "R2 ARM cycle", slot_req_o, 0);
        for (int s = 0; s < N; s++) begin
            int eo, ev, idx;
            logic [23:0] f, o;
            bit ks;
            @(negedge clk);
            eo = O - 1 - s / V;
            ev = s % V;
            idx = eo * V + ev;
            chk(slot_req_o && slot_op_o == eo[2:0] && slot_voice_o == ev[3:0],
                "R3 slot order", {slot_req_o, slot_op_o, slot_voice_o},
                {1'b1, eo[2:0], ev[3:0]});
            if (s > 0) begin
                chk(phase_vld_o && phase_o == prev_exp, "R5/R6/R7 phase", phase_o, prev_exp);
                chk(phase_op_o == prev_op[2:0] && phase_voice_o == prev_v[3:0],
                    "R6 tag", {phase_op_o, phase_voice_o}, {prev_op[2:0], prev_v[3:0]});
                chk(done_o == 1'b0, "R8 early done", done_o, 0);
            end
            tstamp[idx] = cyc;
            if (eo < O - 1)
                chk(tstamp[idx] - tstamp[idx + V] == 16, "R4 operator spacing",
                    tstamp[idx] - tstamp[idx + V], 16);
            unique case (mode)
                1: begin f = '0; o = '0; ks = 1'b0; end
                2: begin f = 24'hFFFFF0 + 24'($urandom_range(15)); o = 24'hFFFFFF; ks = 1'b0; end
                3: begin f = 24'($urandom); o = 24'h000123; ks = (s == ksel); end
                default: begin
                    f = 24'($urandom); o = 24'($urandom);
                    ks = ($urandom_range(7) == 0);
                end
            endcase
            freq_i = f; offs_i = o; ksync_i = ks;
            sync_i = (s == inj);
            ref_ph[idx] = upd(ref_ph[idx], f, ks);
            exp_out = ref_ph[idx] + o;
            prev_exp = exp_out; prev_op = eo; prev_v = ev;
        end
        @(negedge clk);
        sync_i = 1'b0; ksync_i = 1'b0;
        chk(phase_vld_o && phase_o == prev_exp, "R6 last phase", phase_o, prev_exp);
        chk(done_o == 1'b1, "R8 done pulse", done_o, 1);
        chk(slot_req_o == 1'b0, "R9 no restart", slot_req_o, 0);
        repeat (3) begin
            @(negedge clk);
            chk(!done_o && !slot_req_o && !phase_vld_o, "R8 idle after done",
                {done_o, slot_req_o}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        pass(1, -1);           // R1: all phases start at zero
        pass(0, -1);           // R5 R6 R7 random
        pass(0, 40);           // R9 sync mid pass
        pass(1, -1);           // R6 offset not written back
        pass(2, -1);           // R5 wrap
        pass(2, 95);           // R9 sync on last slot
        pass(3, -1);           // R7 single key sync
        pass(0, -1);
        pass(0, 3);
        do_reset();            // R1 second reset
        pass(1, -1);
        pass(0, -1);
        report();
    end

endmodule